// File: doc/BRIEF.md
# Synchronous Optimal PWM Pattern Generator

This block plays back a precomputed quarter-period switching pattern as level commands for the three legs of two inverters that feed an open-end motor winding. A phase accumulator advances by a frequency tuning word on every clock. Each leg folds the accumulator phase into the first quarter period and compares it against the stored switching angles of the active operating point. It then rebuilds the rest of the period by mirroring around 90° and inverting for the second half.

The three legs of the first inverter run the same pattern at offsets of 0°, 120° and 240°. The legs of the second inverter run it at a further 120° lag, so the zero-sequence content of the winding voltage cancels. Software loads several operating points through a write port. The controller picks one with a table index, and it picks two-level or three-level leg encoding with a mode input. A new index or mode takes effect only at the 0° crossing of phase A.

Top module: `sopwm_gen`

## Requirements
- R1: While reset is asserted, and on the cycle after it, every leg output is the zero code and the phase accumulator holds 0.
- R2: The accumulator adds the tuning word every cycle, modulo 65536 phase units for a full turn. A leg output reflects the accumulator value of the previous cycle. In the folded quarter angle q, a stored transition counts once q is greater than or equal to its angle.
- R3: Within the first half period, the phase in 90–180° is folded to q = 16384 − (phase − 16384), which mirrors the pattern around 90°.
- R4: In the second half period (phase ≥ 32768), the pattern is inverted. A two-level leg outputs the complement of its first-half level. A three-level leg outputs the negative code wherever the first half gave the positive code.
- R5: Level codes are 2'b00 zero, 2'b01 positive/high and 2'b10 negative. A two-level leg never outputs the negative code. In the quarter, the leg is at its upper level when the enabled rising transitions already passed outnumber the falling ones.
- R6: Inverter 1 legs A, B and C sit at output bits [1:0], [3:2] and [5:4]. They evaluate the pattern at phase, phase − 21845 and phase − 43691 (mod 65536).
- R7: Inverter 2 legs lag inverter 1 by 120°. Inverter 2 leg A equals inverter 1 leg B, leg B equals leg C, and leg C equals leg A, all on the same bit layout.
- R8: The table index and the leg mode are taken in only on the cycle the accumulator wraps past 0°, so one period never mixes two patterns.
- R9: A write stores a 14-bit quarter angle, a rising flag and an enable flag into one slot of one table. A slot whose enable flag is clear has no effect on the output.
- R10: With N enabled, alternating transitions starting with a rising one, a leg output changes 4N+2 times per period in two-level mode and 4N times per period in three-level mode.
- R11: With a tuning word of 0 and no table write, the leg outputs stay constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ftw_i | input | PHW (16) | Phase increment per cycle |
| tab_sel_i | input | log2(NTAB) (2) | Requested operating-point table |
| three_lvl_i | input | 1 | Requested mode: 1 three-level, 0 two-level |
| wr_en_i | input | 1 | Table write strobe |
| wr_tab_i | input | log2(NTAB) (2) | Table written |
| wr_slot_i | input | log2(MAXN) (3) | Slot written |
| wr_angle_i | input | PHW-2 (14) | Quarter-period angle of the transition |
| wr_rise_i | input | 1 | 1 rising transition, 0 falling |
| wr_used_i | input | 1 | Slot enable |
| inv1_legs_o | output | 6 | Inverter 1 level codes, legs A/B/C |
| inv2_legs_o | output | 6 | Inverter 2 level codes, legs A/B/C |

## Verification
The assertions check four behaviours on every cycle: the accumulator step, the rule that the active table and mode only change across a wrap, the fixed mapping between the two inverters' legs, and the absence of the negative code in two-level mode. They also check that outputs hold when the phase stands still. The folded-angle comparison, the half-wave inversion, the 120° leg offsets and the per-period transition counts can only be shown by the bench. Its scoreboard predicts every output word from its own table copy, and it counts edges over exact periods with several patterns, in both modes and with disabled slots.

// File: rtl/sopwm_pkg.sv
`timescale 1ns/1ps
package sopwm_pkg;
   typedef enum logic [1:0] {
      LVL_ZERO = 2'b00,
      LVL_POS  = 2'b01,
      LVL_NEG  = 2'b10
   } lvl_e;
endpackage

// File: rtl/sopwm_angle_table.sv
`timescale 1ns/1ps
module sopwm_angle_table #(
   parameter int PHW  = 16,
   parameter int MAXN = 8,
   parameter int NTAB = 4,
   localparam int QW   = PHW - 2,
   localparam int IDXW = $clog2(NTAB),
   localparam int SLW  = $clog2(MAXN)
) (
   input  logic                      clk_i,
   input  logic                      rst_i,
   input  logic                      wr_en_i,
   input  logic [IDXW-1:0]           wr_tab_i,
   input  logic [SLW-1:0]            wr_slot_i,
   input  logic [QW-1:0]             wr_angle_i,
   input  logic                      wr_rise_i,
   input  logic                      wr_used_i,
   input  logic [IDXW-1:0]           rd_tab_i,
   output logic [MAXN-1:0][QW-1:0]   ang_o,
   output logic [MAXN-1:0]           rise_o,
   output logic [MAXN-1:0]           used_o
);
   logic [NTAB-1:0][MAXN-1:0][QW-1:0] ang_q;
   logic [NTAB-1:0][MAXN-1:0]         rise_q;
   logic [NTAB-1:0][MAXN-1:0]         used_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ang_q  <= '0;
         rise_q <= '0;
         used_q <= '0;
      end else if (wr_en_i) begin
         ang_q[wr_tab_i][wr_slot_i]  <= wr_angle_i;
         rise_q[wr_tab_i][wr_slot_i] <= wr_rise_i;
         used_q[wr_tab_i][wr_slot_i] <= wr_used_i;
      end
   end

   assign ang_o  = ang_q[rd_tab_i];
   assign rise_o = rise_q[rd_tab_i];
   assign used_o = used_q[rd_tab_i];
endmodule

// File: rtl/sopwm_phase_acc.sv
`timescale 1ns/1ps
module sopwm_phase_acc #(
   parameter int PHW  = 16,
   parameter int IDXW = 2
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic [PHW-1:0]  ftw_i,
   input  logic [IDXW-1:0] sel_i,
   input  logic            three_lvl_i,
   output logic [PHW-1:0]  phase_o,
   output logic [IDXW-1:0] act_sel_o,
   output logic            act_three_o
);
   logic [PHW-1:0]  phase_q;
   logic [IDXW-1:0] sel_q;
   logic            three_q;
   logic [PHW:0]    next_w;

   assign next_w = {1'b0, phase_q} + {1'b0, ftw_i};

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         phase_q <= '0;
         sel_q   <= '0;
         three_q <= 1'b0;
      end else begin
         phase_q <= next_w[PHW-1:0];
         if (next_w[PHW]) begin
            sel_q   <= sel_i;
            three_q <= three_lvl_i;
         end
      end
   end

   assign phase_o     = phase_q;
   assign act_sel_o   = sel_q;
   assign act_three_o = three_q;

   // R2
   acc_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> (phase_q == PHW'($past(phase_q) + $past(ftw_i))));

   // R8
   sel_swap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$stable(sel_q) || !$stable(three_q)) |-> (phase_q < $past(phase_q)));
endmodule

// File: rtl/sopwm_leg_eval.sv
`timescale 1ns/1ps
module sopwm_leg_eval #(
   parameter int PHW    = 16,
   parameter int MAXN   = 8,
   parameter int THIRDS = 0,
   localparam int QW    = PHW - 2,
   localparam int CW    = $clog2(MAXN + 1),
   localparam int unsigned FULL  = 1 << PHW,
   localparam int unsigned THIRD = (FULL + 1) / 3,
   localparam int unsigned SHU   = (THIRDS % 3 == 0) ? 0 :
                                   (THIRDS % 3 == 1) ? THIRD : FULL - THIRD,
   localparam logic [PHW-1:0] SH = SHU[PHW-1:0]
) (
   input  logic [PHW-1:0]            phase_i,
   input  logic [MAXN-1:0][QW-1:0]   ang_i,
   input  logic [MAXN-1:0]           rise_i,
   input  logic [MAXN-1:0]           used_i,
   input  logic                      three_lvl_i,
   output sopwm_pkg::lvl_e           code_o
);
   import sopwm_pkg::*;

   logic [PHW-1:0] ph;
   logic [QW:0]    qa;
   logic           second_half;
   logic [CW-1:0]  n_up, n_dn;
   logic           hi;

   always_comb begin
      ph          = phase_i - SH;
      second_half = ph[PHW-1];
      // fold the second quarter of each half back onto the first
      if (ph[PHW-2])
         qa = {1'b1, {QW{1'b0}}} - {1'b0, ph[QW-1:0]};
      else
         qa = {1'b0, ph[QW-1:0]};
      n_up = '0;
      n_dn = '0;
      for (int i = 0; i < MAXN; i++) begin
         if (used_i[i] && (qa >= {1'b0, ang_i[i]})) begin
            if (rise_i[i]) n_up = n_up + CW'(1);
            else           n_dn = n_dn + CW'(1);
         end
      end
      hi = (n_up > n_dn);
      if (three_lvl_i)
         code_o = hi ? (second_half ? LVL_NEG : LVL_POS) : LVL_ZERO;
      else
         code_o = (hi ^ second_half) ? LVL_POS : LVL_ZERO;
   end
endmodule

// File: rtl/sopwm_gen.sv
`timescale 1ns/1ps
module sopwm_gen #(
   parameter int PHW  = 16,
   parameter int MAXN = 8,
   parameter int NTAB = 4,
   localparam int QW   = PHW - 2,
   localparam int IDXW = $clog2(NTAB),
   localparam int SLW  = $clog2(MAXN),
   localparam int LEGS = 6
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic [PHW-1:0]  ftw_i,
   input  logic [IDXW-1:0] tab_sel_i,
   input  logic            three_lvl_i,
   input  logic            wr_en_i,
   input  logic [IDXW-1:0] wr_tab_i,
   input  logic [SLW-1:0]  wr_slot_i,
   input  logic [QW-1:0]   wr_angle_i,
   input  logic            wr_rise_i,
   input  logic            wr_used_i,
   output logic [5:0]      inv1_legs_o,
   output logic [5:0]      inv2_legs_o
);
   import sopwm_pkg::*;

   if (PHW < 8 || PHW > 24) begin : g_bad_phw
      $error("sopwm_gen: PHW out of range");
   end
   if (MAXN < 2 || (1 << SLW) != MAXN) begin : g_bad_maxn
      $error("sopwm_gen: MAXN must be a power of two >= 2");
   end
   if (NTAB < 2 || (1 << IDXW) != NTAB) begin : g_bad_ntab
      $error("sopwm_gen: NTAB must be a power of two >= 2");
   end

   logic [PHW-1:0]          phase_w;
   logic [IDXW-1:0]         act_sel_w;
   logic                    act_three_w;
   logic [MAXN-1:0][QW-1:0] ang_w;
   logic [MAXN-1:0]         rise_w, used_w;
   lvl_e                    code_w [LEGS];
   logic [LEGS-1:0][1:0]    legs_q;

   sopwm_phase_acc #(.PHW(PHW), .IDXW(IDXW)) u_acc (
      .clk_i(clk_i), .rst_i(rst_i), .ftw_i(ftw_i), .sel_i(tab_sel_i),
      .three_lvl_i(three_lvl_i), .phase_o(phase_w),
      .act_sel_o(act_sel_w), .act_three_o(act_three_w));

   sopwm_angle_table #(.PHW(PHW), .MAXN(MAXN), .NTAB(NTAB)) u_tab (
      .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_tab_i(wr_tab_i),
      .wr_slot_i(wr_slot_i), .wr_angle_i(wr_angle_i), .wr_rise_i(wr_rise_i),
      .wr_used_i(wr_used_i), .rd_tab_i(act_sel_w),
      .ang_o(ang_w), .rise_o(rise_w), .used_o(used_w));

   // leg j: inverter j/3, phase j%3; total lag in thirds of a turn
   for (genvar j = 0; j < LEGS; j++) begin : g_leg
      sopwm_leg_eval #(.PHW(PHW), .MAXN(MAXN), .THIRDS((j % 3) + (j / 3))) u_eval (
         .phase_i(phase_w), .ang_i(ang_w), .rise_i(rise_w), .used_i(used_w),
         .three_lvl_i(act_three_w), .code_o(code_w[j]));

      always_ff @(posedge clk_i) begin
         if (rst_i) legs_q[j] <= LVL_ZERO;
         else       legs_q[j] <= code_w[j];
      end
   end

   assign inv1_legs_o = legs_q[2:0];
   assign inv2_legs_o = legs_q[5:3];

   logic neg_any;
   assign neg_any = legs_q[0][1] | legs_q[1][1] | legs_q[2][1] |
                    legs_q[3][1] | legs_q[4][1] | legs_q[5][1];

   // R1
   rst_zero_chk: assert property (@(posedge clk_i)
      rst_i |=> (legs_q == '0));

   // R5
   two_lvl_no_neg_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(act_three_w) |-> !neg_any);

   // R7
   inv2_lag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (legs_q[3] == legs_q[1]) && (legs_q[4] == legs_q[2]) && (legs_q[5] == legs_q[0]));

   // R11
   hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && (phase_w == $past(phase_w)) && !$past(wr_en_i)) |=> $stable(legs_q));
endmodule

// File: tb/sopwm_gen_bench.sv
`timescale 1ns/1ps
module sopwm_gen_bench;
   localparam int PHW  = 16;
   localparam int MAXN = 8;
   localparam int NTAB = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] ftw = '0;
   logic [1:0]  tab_sel = '0;
   logic        three_lvl = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_tab = '0;
   logic [2:0]  wr_slot = '0;
   logic [13:0] wr_angle = '0;
   logic        wr_rise = 1'b0;
   logic        wr_used = 1'b0;
   logic [5:0]  inv1, inv2;

   always #2.5 clk = ~clk;

   sopwm_gen #(.PHW(PHW), .MAXN(MAXN), .NTAB(NTAB)) u_sopwm_gen (
      .clk_i(clk), .rst_i(rst), .ftw_i(ftw), .tab_sel_i(tab_sel),
      .three_lvl_i(three_lvl), .wr_en_i(wr_en), .wr_tab_i(wr_tab),
      .wr_slot_i(wr_slot), .wr_angle_i(wr_angle), .wr_rise_i(wr_rise),
      .wr_used_i(wr_used), .inv1_legs_o(inv1), .inv2_legs_o(inv2));

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_tag = "R1";

   // bench-side model of the operating points and phase
   int m_ang  [NTAB][MAXN];
   bit m_rise [NTAB][MAXN];
   bit m_used [NTAB][MAXN];
   int m_acc = 0;
   int m_act = 0;
   bit m_three = 1'b0;
   logic [11:0] exp_q [$];

   task automatic check(input bit ok, input string tag, input int got, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   function automatic logic [1:0] leg_code(input int ph);
      bit half = (ph >= 32768);
      int r    = ph % 32768;
      int q    = (r < 16384) ? r : 32768 - r;
      int lvl  = 0;
      bit hi;
      for (int i = 0; i < MAXN; i++)
         if (m_used[m_act][i] && q >= m_ang[m_act][i])
            lvl += m_rise[m_act][i] ? 1 : -1;
      hi = (lvl > 0);
      if (m_three) return hi ? (half ? 2'b10 : 2'b01) : 2'b00;
      return (hi != half) ? 2'b01 : 2'b00;
   endfunction

   function automatic logic [11:0] model_out();
      logic [11:0] r;
      for (int j = 0; j < 6; j++) begin
         int th = (j % 3) + (j / 3);
         int sh = (th % 3 == 0) ? 0 : (th % 3 == 1) ? 21845 : 43691;
         r[2*j +: 2] = leg_code((m_acc - sh + 65536) % 65536);
      end
      return r;
   endfunction

   // predictor: expected word for the register update at this edge
   always @(posedge clk) begin
      if (rst) begin
         exp_q.push_back(12'h000);
         m_acc = 0; m_act = 0; m_three = 1'b0;
         for (int t = 0; t < NTAB; t++)
            for (int s = 0; s < MAXN; s++) begin
               m_ang[t][s] = 0; m_rise[t][s] = 1'b0; m_used[t][s] = 1'b0;
            end
      end else begin
         int nxt;
         exp_q.push_back(model_out());
         if (wr_en) begin
            m_ang[wr_tab][wr_slot]  = int'(wr_angle);
            m_rise[wr_tab][wr_slot] = wr_rise;
            m_used[wr_tab][wr_slot] = wr_used;
         end
         nxt = m_acc + int'(ftw);
         if (nxt >= 65536) begin
            m_act = int'(tab_sel);
            m_three = three_lvl;
         end
         m_acc = nxt % 65536;
      end
   end

   // monitor: compare each produced word with the queued expectation
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [11:0] e;
         e = exp_q.pop_front();
         check({inv2, inv1} == e, cur_tag, int'({inv2, inv1}), int'(e));
      end
   end

   task automatic put_slot(input int t, input int s, input int a, input bit r, input bit u);
      @(negedge clk);
      wr_en = 1'b1; wr_tab = 2'(t); wr_slot = 3'(s);
      wr_angle = 14'(a); wr_rise = r; wr_used = u;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic count_edges(input int cycles, output int n);
      logic [1:0] prev;
      n = 0;
      @(negedge clk);
      prev = inv1[1:0];
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         if (inv1[1:0] != prev) n++;
         prev = inv1[1:0];
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired, run hung");
      finish_run();
   end

   initial begin
      int n;
      // R1: reset state
      repeat (5) @(negedge clk);
      check(inv1 == 6'h00 && inv2 == 6'h00, "R1 reset legs", int'({inv2, inv1}), 0);
      rst = 1'b0;

      cur_tag = "R9 load";
      put_slot(0, 0, 2000, 1'b1, 1'b1);
      put_slot(0, 1, 6000, 1'b0, 1'b1);
      put_slot(0, 2, 10000, 1'b1, 1'b1);
      put_slot(1, 0, 4096, 1'b1, 1'b1);
      put_slot(1, 1, 12288, 1'b0, 1'b1);

      // two-level, table 0, exact 128-cycle period
      cur_tag = "R2 R3 R4 R5 R6 R7 two-level";
      ftw = 16'd512; tab_sel = 2'd0; three_lvl = 1'b0;
      repeat (256) @(negedge clk);
      count_edges(128, n);
      check(n == 14, "R10 two-level edges N=3", n, 14);

      // three-level, same table
      cur_tag = "R2 R3 R4 R5 R6 R7 three-level";
      three_lvl = 1'b1;
      repeat (256) @(negedge clk);
      count_edges(128, n);
      check(n == 12, "R10 three-level edges N=3", n, 12);

      // odd step and mid-period operating point change
      cur_tag = "R8 R2 R6 mid-period switch";
      ftw = 16'd1237;
      repeat (37) @(negedge clk);
      tab_sel = 2'd1;
      repeat (90) @(negedge clk);
      three_lvl = 1'b0;
      repeat (23) @(negedge clk);
      tab_sel = 2'd0;
      repeat (200) @(negedge clk);

      // disabled slot must not change the pattern
      cur_tag = "R9 disabled slot";
      put_slot(0, 5, 3000, 1'b1, 1'b0);
      ftw = 16'd512; three_lvl = 1'b0; tab_sel = 2'd0;
      repeat (256) @(negedge clk);
      count_edges(128, n);
      check(n == 14, "R9 disabled slot edges", n, 14);

      // stalled phase
      cur_tag = "R11 hold";
      ftw = 16'd0;
      repeat (4) @(negedge clk);
      count_edges(50, n);
      check(n == 0, "R11 hold edges", n, 0);

      // empty table: square wave in two-level mode
      cur_tag = "R10 empty table";
      ftw = 16'd512; tab_sel = 2'd2;
      repeat (256) @(negedge clk);
      count_edges(128, n);
      check(n == 2, "R10 two-level edges N=0", n, 2);
      three_lvl = 1'b1;
      repeat (256) @(negedge clk);
      count_edges(128, n);
      check(n == 0, "R10 three-level edges N=0", n, 0);

      // table 1, three-level, N=2
      tab_sel = 2'd1;
      repeat (256) @(negedge clk);
      count_edges(128, n);
      check(n == 8, "R10 three-level edges N=2", n, 8);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule